// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character per request into an asynchronous serial frame on a single output line. Each frame is a low start bit, five to nine data bits, an optional extra bit in the parity slot, and a mark-level stop period. The frame shape comes from static configuration inputs: the character length, which end of the character goes out first, the kind of parity slot, and the stop length. A separate 9-bit select overrides the length field.

Timing comes from an external tick strobe that runs at sixteen times the bit rate. Each bit holds for sixteen ticks, so a fractional-rate divider upstream can space its ticks unevenly and the bit edges still stay aligned. The request side uses a valid/ready handshake. Ready is high only while the line is idle. The block captures the character and the decoded frame at the moment of acceptance, and a busy flag covers the whole frame.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is 1, `busy` is 0 and `in_ready` is 1. During a frame `in_ready` is 0 and `busy` is 1.
- R2: An accepted character starts with a start bit at level 0. The start bit and every following data or parity bit last exactly 16 tick strobes.
- R3: When `cfg_nine` is 1 the character has 9 bits. Otherwise `cfg_len` sets the length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the active length are not sent.
- R4: `cfg_msb_first` = 0 sends bit 0 of `in_data` first. `cfg_msb_first` = 1 sends the highest active bit first.
- R5: `cfg_parity` 000 adds a bit that makes the number of ones across the active data bits and the added bit even. Code 001 makes that number odd.
- R6: `cfg_parity` 010 adds a bit that is always 0. Code 011 adds a bit that is always 1.
- R7: `cfg_parity` 100 or 101 adds no bit: the stop period follows the last data bit directly.
- R8: `cfg_parity` 110 or 111 adds a bit that equals `in_addr_flag` (1 marks an address character).
- R9: The stop period is at level 1. Its length is 16 ticks for `cfg_stop` 00, 24 ticks for 01, 32 ticks for 10, and 16 ticks for the reserved code 11. At the end of the stop period the block returns to idle.
- R10: `in_valid` and `in_data` have no effect while a frame is in progress. The frame carries the character and configuration present at the cycle of acceptance.
- R11: In a cycle without a tick strobe the line level and the frame position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 16x the bit rate |
| in_valid | input | 1 | Character request |
| in_ready | output | 1 | High when a request will be accepted (idle) |
| in_data | input | 9 | Character, right-aligned |
| in_addr_flag | input | 1 | Address/data flag used in multidrop parity mode |
| cfg_len | input | 2 | Character length: 5 + value |
| cfg_nine | input | 1 | Forces a 9-bit character |
| cfg_msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| cfg_parity | input | 3 | Kind of parity slot |
| cfg_stop | input | 2 | Stop length code |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The bench uses the default parameters: a 9-bit data path and 16 ticks per bit. With these values every length code, the 9-bit override, and the 24-tick stop period, which exists only for an even oversampling factor, can all be exercised. The tick strobe arrives with random gaps, so stalls fall at every position in the frame, including the last tick of the start bit and the last tick of the stop period. Junk requests are driven during frames to show that a character is captured only once, at acceptance.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    // parity slot selector codes
    localparam logic [2:0] PAR_EVEN  = 3'b000;
    localparam logic [2:0] PAR_ODD   = 3'b001;
    localparam logic [2:0] PAR_SPACE = 3'b010;
    localparam logic [2:0] PAR_MARK  = 3'b011;

    // stop length codes
    localparam logic [1:0] STOP_ONE  = 2'b00;
    localparam logic [1:0] STOP_HALF = 2'b01;
    localparam logic [1:0] STOP_TWO  = 2'b10;

endpackage

// File: rtl/uart_tx_parity.sv
// Parity of the masked data bits (1 when the count of ones is odd).
module uart_tx_parity #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits_i,
    input  logic [W-1:0] mask_i,
    output logic         odd_o
);
    assign odd_o = ^(bits_i & mask_i);
endmodule

// File: rtl/uart_tx_frame_build.sv
// Builds the payload shift word (data + optional parity slot, first bit at index 0).
module uart_tx_frame_build
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 9,
    localparam int FW    = DATA_W + 1,
    localparam int CW    = $clog2(FW + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              addr_flag_i,
    input  logic [1:0]        len_i,
    input  logic              nine_i,
    input  logic              msb_first_i,
    input  logic [2:0]        parity_i,
    output logic [FW-1:0]     frame_o,
    output logic [CW-1:0]     nbits_o
);
    int                len;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] ordered;
    logic              ones_odd;
    logic              has_par;
    logic              par_bit;

    uart_tx_parity #(.W(DATA_W)) par_i (
        .bits_i (data_i),
        .mask_i (mask),
        .odd_o  (ones_odd)
    );

    always_comb begin
        len     = nine_i ? DATA_W : 5 + int'(len_i);
        mask    = '0;
        ordered = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (j < len) begin
                mask[j] = 1'b1;
                if (msb_first_i) ordered[len-1-j] = data_i[j];
                else             ordered[j]       = data_i[j];
            end
        end

        has_par = 1'b1;
        par_bit = 1'b0;
        casez (parity_i)
            PAR_EVEN:  par_bit = ones_odd;
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_SPACE: par_bit = 1'b0;
            PAR_MARK:  par_bit = 1'b1;
            3'b10?:    has_par = 1'b0;
            default:   par_bit = addr_flag_i;
        endcase

        frame_o = {1'b0, ordered};
        if (has_par) frame_o[len] = par_bit;
        nbits_o = CW'(len) + CW'(has_par);
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_addr_flag,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_nine,
    input  logic              cfg_msb_first,
    input  logic [2:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    output logic              tx,
    output logic              busy
);
    localparam int FW      = DATA_W + 1;
    localparam int CW      = $clog2(FW + 1);
    localparam int CNT_W   = $clog2(2 * OVS);
    localparam int STOP15  = OVS + OVS / 2;

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [FW-1:0]    shf;
        logic [CW-1:0]    left;
        logic [CNT_W-1:0] stop_last;
    } regs_t;

    regs_t            r_d, r_q;
    logic [FW-1:0]    frame;
    logic [CW-1:0]    nbits;
    logic [CNT_W-1:0] stop_last_sel;

    uart_tx_frame_build #(.DATA_W(DATA_W)) build_i (
        .data_i      (in_data),
        .addr_flag_i (in_addr_flag),
        .len_i       (cfg_len),
        .nine_i      (cfg_nine),
        .msb_first_i (cfg_msb_first),
        .parity_i    (cfg_parity),
        .frame_o     (frame),
        .nbits_o     (nbits)
    );

    always_comb begin
        case (cfg_stop)
            STOP_HALF: stop_last_sel = CNT_W'(STOP15 - 1);
            STOP_TWO:  stop_last_sel = CNT_W'(2 * OVS - 1);
            default:   stop_last_sel = CNT_W'(OVS - 1);
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.st        = ST_START;
                    r_d.cnt       = '0;
                    r_d.shf       = frame;
                    r_d.left      = nbits;
                    r_d.stop_last = stop_last_sel;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (r_q.cnt == CNT_W'(OVS - 1)) begin
                        r_d.st  = ST_BITS;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_BITS: begin
                if (tick) begin
                    if (r_q.cnt == CNT_W'(OVS - 1)) begin
                        r_d.cnt = '0;
                        r_d.shf = r_q.shf >> 1;
                        if (r_q.left == CW'(1)) r_d.st = ST_STOP;
                        else                    r_d.left = r_q.left - 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (r_q.cnt == r_q.stop_last) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, shf: '0, left: '0, stop_last: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.st == ST_IDLE);
    assign busy     = (r_q.st != ST_IDLE);
    assign tx       = (r_q.st == ST_START) ? 1'b0 :
                      (r_q.st == ST_BITS)  ? r_q.shf[0] : 1'b1;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic tx,
    input logic busy
);
    assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(tx) && busy));

    assert_stop_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tick) && $past(tx)));
endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (.*);

// File: tb/uart_tx_framer_tb_top.sv
`timescale 1ns/1ps
module uart_tx_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic       in_addr_flag = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_nine = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [2:0] cfg_parity = 3'b100;
    logic [1:0] cfg_stop = 2'b00;
    logic       tx;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_tx_framer dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Expected payload levels (data then parity slot) from the requirements.
    task automatic model(input logic [8:0] d, input logic af, input logic [1:0] ln,
                         input logic nine, input logic msb, input logic [2:0] par,
                         input logic [1:0] stp, output logic [11:0] lv,
                         output int nlev, output int stop_t);
        int len;
        int ones;
        len  = nine ? 9 : 5 + int'(ln);
        lv   = '0;
        lv[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < len; i++) begin
            lv[1+i] = msb ? d[len-1-i] : d[i];
            ones += int'(d[i]);
        end
        nlev = 1 + len;
        case (par)
            3'b000: begin lv[nlev] = (ones % 2) == 1; nlev++; end
            3'b001: begin lv[nlev] = (ones % 2) == 0; nlev++; end
            3'b010: begin lv[nlev] = 1'b0; nlev++; end
            3'b011: begin lv[nlev] = 1'b1; nlev++; end
            3'b110, 3'b111: begin lv[nlev] = af; nlev++; end
            default: ;
        endcase
        case (stp)
            2'b01:   stop_t = 24;
            2'b10:   stop_t = 32;
            default: stop_t = 16;
        endcase
    endtask

    task automatic send(input logic [8:0] d, input logic af, input logic [1:0] ln,
                        input logic nine, input logic msb, input logic [2:0] par,
                        input logic [1:0] stp, input bit junk, input int dens,
                        input string req);
        logic [11:0] lv;
        int nlev, stop_t, total, k, t;
        bit bad_tx, bad_busy;
        int bad_k_tx, act_tx, exp_tx, end_k;
        model(d, af, ln, nine, msb, par, stp, lv, nlev, stop_t);
        total = 16 * nlev + stop_t;
        @(negedge clk);
        chk(in_ready === 1'b1 && busy === 1'b0, "R1", "ready before request",
            int'(in_ready), 1);
        in_data = d; in_addr_flag = af; cfg_len = ln; cfg_nine = nine;
        cfg_msb_first = msb; cfg_parity = par; cfg_stop = stp;
        in_valid = 1'b1;
        tick = ($urandom % 2) == 1;
        @(negedge clk);
        in_valid = 1'b0;
        k = 0; bad_tx = 0; bad_busy = 0; bad_k_tx = 0; act_tx = 0; exp_tx = 0;
        end_k = -1;
        forever begin
            exp_tx = (k < 16 * nlev) ? int'(lv[k/16]) : 1;
            if (int'(tx) != exp_tx && !bad_tx) begin
                bad_tx = 1; bad_k_tx = k; act_tx = int'(tx);
            end
            if (busy !== (k < total) && !bad_busy) begin
                bad_busy = 1; end_k = k;
            end
            if (k == total) break;
            t = (($urandom % 100) < dens) ? 1 : 0;
            tick = t[0];
            if (junk) begin
                in_valid = $urandom % 2;
                in_data  = 9'($urandom);
                in_addr_flag = $urandom % 2;
            end
            @(negedge clk);
            k += t;
        end
        in_valid = 1'b0;
        tick = 1'b0;
        if (bad_tx)
            $display("  at tick %0d of frame (%s)", bad_k_tx, req);
        chk(!bad_tx, req, "tx level", act_tx,
            bad_tx ? int'(!act_tx) : act_tx);
        chk(!bad_busy, "R9", "frame length in ticks", bad_busy ? end_k : total, total);
        chk(in_ready === 1'b1 && tx === 1'b1, "R1", "idle after frame",
            int'(in_ready), 1);
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (4) @(negedge clk);
        chk(tx === 1'b1, "R1", "tx in reset", int'(tx), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1", "reset state",
            int'({tx, busy, in_ready}), 5);

        // directed corners
        send(9'h0A5, 0, 2'b11, 0, 0, 3'b000, 2'b00, 0, 60, "R5");  // even
        send(9'h007, 0, 2'b11, 0, 0, 3'b001, 2'b00, 0, 60, "R5");  // odd
        send(9'h0FF, 0, 2'b10, 0, 0, 3'b010, 2'b00, 0, 60, "R6");  // space
        send(9'h000, 0, 2'b01, 0, 0, 3'b011, 2'b00, 0, 60, "R6");  // mark
        send(9'h1F5, 0, 2'b00, 0, 0, 3'b100, 2'b00, 0, 60, "R7");  // none, 5 bits
        send(9'h115, 0, 2'b00, 0, 1, 3'b101, 2'b00, 0, 60, "R3");  // upper bits dropped
        send(9'h0C3, 1, 2'b11, 0, 0, 3'b110, 2'b00, 0, 60, "R8");  // address
        send(9'h0C3, 0, 2'b11, 0, 0, 3'b111, 2'b00, 0, 60, "R8");  // data
        send(9'h13C, 0, 2'b00, 1, 1, 3'b000, 2'b00, 0, 60, "R4");  // nine, MSB first
        send(9'h101, 0, 2'b01, 1, 0, 3'b100, 2'b00, 0, 60, "R3");  // nine, LSB first
        send(9'h02D, 0, 2'b01, 0, 1, 3'b100, 2'b00, 0, 60, "R4");  // 6 bits MSB
        send(9'h055, 0, 2'b11, 0, 0, 3'b100, 2'b01, 0, 60, "R9");  // 1.5 stop
        send(9'h055, 0, 2'b11, 0, 0, 3'b100, 2'b10, 0, 60, "R9");  // 2 stop
        send(9'h055, 0, 2'b11, 0, 0, 3'b100, 2'b11, 0, 60, "R9");  // reserved
        send(9'h0E1, 1, 2'b11, 0, 0, 3'b000, 2'b00, 1, 60, "R10"); // junk requests
        send(9'h0B2, 0, 2'b10, 0, 1, 3'b001, 2'b01, 0, 15, "R11"); // sparse ticks
        send(9'h033, 0, 2'b11, 0, 0, 3'b010, 2'b00, 0, 100, "R2"); // tick every cycle

        // constrained random frames
        for (int n = 0; n < 110; n++) begin
            logic [2:0] p;
            logic [1:0] s;
            p = 3'($urandom);
            s = 2'($urandom);
            send(9'($urandom), 1'($urandom), 2'($urandom), ($urandom % 4) == 0,
                 1'($urandom), p, s, ($urandom % 2) == 1, 30 + int'($urandom % 71),
                 "R2");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule